// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This combinational block shapes the second operand of a data-processing unit. It shifts or rotates a 32-bit source value by an amount and produces the shifted result together with the shifter carry-out. The shift kind is one of four: logical left, logical right, arithmetic right and rotate right. The amount can come from one of two places:

- a 5-bit field carried in the instruction, in which a zero has a special meaning for each kind;
- the low byte of a register, which can reach 255.

A separate mode ignores the source and the amount altogether. Instead it builds a constant from an 8-bit value rotated right by twice a 4-bit field. The outputs feed the ALU directly, with no register in the path.

Top module: `barrel_shifter`

## Requirements
- R1: With a register amount from 1 to 31, the kind code selects the operation: 0 is logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The carry-out is the last bit shifted out. For rotate it is bit 31 of the result.
- R2: In constant mode (`rot_imm_mode_i`=1), the result is the 8-bit value, zero-extended, rotated right by twice the 4-bit field. The carry-out is result bit 31 when the field is nonzero, and `carry_i` when the field is zero.
- R3: An instruction amount of 0 with logical left returns the source unchanged, and the carry-out equals `carry_i`.
- R4: An instruction amount of 0 with logical right gives result 0, and the carry-out is source bit 31.
- R5: An instruction amount of 0 with arithmetic right fills every result bit with source bit 31, and the carry-out is source bit 31.
- R6: An instruction amount of 0 with rotate right does a one-bit rotate through carry. The result is {`carry_i`, source[31:1]} and the carry-out is source bit 0.
- R7: When the amount comes from the instruction (`amt_imm_i`=1), only `amt_i[4:0]` is used, and bits 7:5 have no effect on the outputs.
- R8: A register amount of 0 returns the source and `carry_i` unchanged for every kind.
- R9: With a register amount of 32, logical left gives 0 with carry source bit 0, and logical right gives 0 with carry source bit 31. Above 32, both give 0 with carry 0.
- R10: A register arithmetic right shift of 32 or more fills the result and the carry-out with source bit 31.
- R11: A register rotate uses the amount modulo 32. A nonzero multiple of 32 returns the source unchanged, with carry-out equal to source bit 31.
- R12: In constant mode, `src_i`, `amt_i`, `kind_i` and `amt_imm_i` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | DATA_W (32) | Value to shift |
| amt_i | input | AMT_W (8) | Shift amount; only bits 4:0 are used when `amt_imm_i` is 1 |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| amt_imm_i | input | 1 | 1: the amount is an instruction field; 0: it is a register byte |
| carry_i | input | 1 | Incoming carry flag |
| rot_imm_mode_i | input | 1 | Selects the rotated-constant mode |
| imm_val_i | input | IMM_W (8) | 8-bit constant value |
| rot_field_i | input | ROT_W (4) | Rotate field; the rotation is twice this value |
| result_o | output | DATA_W (32) | Shifted or rotated result |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The checker tests every change of the inputs against fixed-form cases. These are the four zero-amount instruction remaps, a register amount of zero, logical shifts beyond 32, arithmetic saturation, and a constant whose rotate field is zero; each of these has a closed-form answer.

The general cases have no such answer and are covered only by the bench's vectors and sweeps. These are partial shifts with their carry bit, rotation modulo 32, the value of a nonzero constant rotation, and the fact that ignored inputs stay ignored.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;
endpackage

// File: rtl/bshift_amt_norm.sv
// Turns the raw amount into an effective amount; remaps zero instruction amounts.
module bshift_amt_norm
  import bshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5,
  parameter int N_W       = 8
) (
  input  logic [AMT_W-1:0] amt_i,
  input  sh_kind_e         kind_i,
  input  logic             amt_imm_i,
  output logic [N_W-1:0]   n_o,
  output logic             rrx_o
);
  localparam logic [N_W-1:0] FULL_N = N_W'(DATA_W);

  logic [IMM_AMT_W-1:0] imm_amt;
  assign imm_amt = amt_i[IMM_AMT_W-1:0];

  always_comb begin
    rrx_o = 1'b0;
    n_o   = N_W'(amt_i);
    if (amt_imm_i) begin
      n_o = N_W'(imm_amt);
      if (imm_amt == '0) begin
        unique case (kind_i)
          SH_LSL: n_o = '0;
          SH_LSR, SH_ASR: n_o = FULL_N;
          SH_ROR: begin
            n_o   = '0;
            rrx_o = 1'b1;
          end
          default: n_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/bshift_core.sv
// Shift datapath on the effective amount; all four kinds plus rotate-through-carry.
module bshift_core
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_W    = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  sh_kind_e          kind_i,
  input  logic [N_W-1:0]    n_i,
  input  logic              rrx_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam logic [N_W-1:0]   FULL_N = N_W'(DATA_W);
  localparam logic [LOG_W:0]   FULL_R = (LOG_W+1)'(DATA_W);

  logic [DATA_W:0]          lsl_full, lsr_full, asr_full;
  logic signed [DATA_W:0]   asr_src;
  logic [N_W-1:0]           asr_n;
  logic [LOG_W-1:0]         rot_n;
  logic [LOG_W:0]           rot_inv;
  logic [DATA_W-1:0]        ror_val;

  // One extra bit on the far side of each shift catches the carry.
  assign lsl_full = {1'b0, src_i} << n_i;
  assign lsr_full = {src_i, 1'b0} >> n_i;
  assign asr_n    = (n_i > FULL_N) ? FULL_N : n_i;
  assign asr_src  = $signed({src_i, 1'b0});
  assign asr_full = asr_src >>> asr_n;
  assign rot_n    = n_i[LOG_W-1:0];
  assign rot_inv  = FULL_R - {1'b0, rot_n};
  assign ror_val  = (src_i >> rot_n) | (src_i << rot_inv);

  always_comb begin
    result_o = src_i;
    carry_o  = carry_i;
    if (rrx_i) begin
      result_o = {carry_i, src_i[DATA_W-1:1]};
      carry_o  = src_i[0];
    end else if (n_i != '0) begin
      unique case (kind_i)
        SH_LSL: begin
          result_o = lsl_full[DATA_W-1:0];
          carry_o  = lsl_full[DATA_W];
        end
        SH_LSR: begin
          result_o = lsr_full[DATA_W:1];
          carry_o  = lsr_full[0];
        end
        SH_ASR: begin
          result_o = asr_full[DATA_W:1];
          carry_o  = asr_full[0];
        end
        SH_ROR: begin
          result_o = ror_val;
          carry_o  = ror_val[DATA_W-1];
        end
        default: begin
          result_o = src_i;
          carry_o  = carry_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/bshift_rot_imm.sv
// Rotated constant: zero-extended value rotated right by 2*field, one mux per bit.
module bshift_rot_imm #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  val_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int LOG_W = $clog2(DATA_W);

  logic [DATA_W-1:0] ext;
  logic [ROT_W:0]    rot2;

  assign ext  = {{(DATA_W-IMM_W){1'b0}}, val_i};
  assign rot2 = {rot_i, 1'b0};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic [LOG_W-1:0] idx;
    assign idx         = LOG_W'(i) + LOG_W'(rot2);
    assign result_o[i] = ext[idx];
  end

  assign carry_o = (rot_i != '0) ? result_o[DATA_W-1] : carry_i;
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import bshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [1:0]        kind_i,
  input  logic              amt_imm_i,
  input  logic              carry_i,
  input  logic              rot_imm_mode_i,
  input  logic [IMM_W-1:0]  imm_val_i,
  input  logic [ROT_W-1:0]  rot_field_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam int N_W   = (AMT_W > LOG_W) ? AMT_W : LOG_W + 1;

  sh_kind_e          kind;
  logic [N_W-1:0]    eff_n;
  logic              eff_rrx;
  logic [DATA_W-1:0] sh_res, ri_res;
  logic              sh_c, ri_c;

  assign kind = sh_kind_e'(kind_i);

  bshift_amt_norm #(
    .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W), .N_W(N_W)
  ) u_norm (
    .amt_i(amt_i), .kind_i(kind), .amt_imm_i(amt_imm_i),
    .n_o(eff_n), .rrx_o(eff_rrx)
  );

  bshift_core #(.DATA_W(DATA_W), .N_W(N_W)) u_core (
    .src_i(src_i), .kind_i(kind), .n_i(eff_n), .rrx_i(eff_rrx),
    .carry_i(carry_i), .result_o(sh_res), .carry_o(sh_c)
  );

  bshift_rot_imm #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .val_i(imm_val_i), .rot_i(rot_field_i), .carry_i(carry_i),
    .result_o(ri_res), .carry_o(ri_c)
  );

  assign result_o = rot_imm_mode_i ? ri_res : sh_res;
  assign carry_o  = rot_imm_mode_i ? ri_c   : sh_c;
endmodule

// File: rtl/barrel_shifter_chk.sv
module barrel_shifter_chk #(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4
) (
  input logic [DATA_W-1:0] src_i,
  input logic [AMT_W-1:0]  amt_i,
  input logic [1:0]        kind_i,
  input logic              amt_imm_i,
  input logic              carry_i,
  input logic              rot_imm_mode_i,
  input logic [IMM_W-1:0]  imm_val_i,
  input logic [ROT_W-1:0]  rot_field_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);
  localparam logic [AMT_W-1:0] FULL_A = AMT_W'(DATA_W);

  logic imm_zero, reg_mode, imm_mode;
  assign imm_mode = !rot_imm_mode_i && amt_imm_i;
  assign reg_mode = !rot_imm_mode_i && !amt_imm_i;
  assign imm_zero = imm_mode && (amt_i[IMM_AMT_W-1:0] == '0);

  always_comb begin
    if (imm_zero && kind_i == 2'd0)
      p_imm_lsl0_r3: assert (result_o == src_i && carry_o == carry_i)
        else $error("imm LSL #0 not a pass-through");
    if (imm_zero && kind_i == 2'd1)
      p_imm_lsr0_r4: assert (result_o == '0 && carry_o == src_i[DATA_W-1])
        else $error("imm LSR #0 not a shift by width");
    if (imm_zero && kind_i == 2'd2)
      p_imm_asr0_r5: assert (result_o == {DATA_W{src_i[DATA_W-1]}} && carry_o == src_i[DATA_W-1])
        else $error("imm ASR #0 not a sign fill");
    if (imm_zero && kind_i == 2'd3)
      p_imm_rrx_r6: assert (result_o == {carry_i, src_i[DATA_W-1:1]} && carry_o == src_i[0])
        else $error("imm ROR #0 not a rotate through carry");
    if (reg_mode && amt_i == '0)
      p_reg_zero_r8: assert (result_o == src_i && carry_o == carry_i)
        else $error("register amount 0 altered operand");
    if (reg_mode && amt_i > FULL_A && kind_i < 2'd2)
      p_reg_over_r9: assert (result_o == '0 && !carry_o)
        else $error("logical shift beyond width not cleared");
    if (reg_mode && amt_i >= FULL_A && kind_i == 2'd2)
      p_reg_asr_sat_r10: assert (result_o == {DATA_W{src_i[DATA_W-1]}} && carry_o == src_i[DATA_W-1])
        else $error("arithmetic shift not saturated");
    if (rot_imm_mode_i && rot_field_i == '0)
      p_const_norot_r2: assert (result_o == DATA_W'(imm_val_i) && carry_o == carry_i)
        else $error("unrotated constant wrong");
  end
endmodule

bind barrel_shifter barrel_shifter_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (
  .src_i(src_i), .amt_i(amt_i), .kind_i(kind_i), .amt_imm_i(amt_imm_i),
  .carry_i(carry_i), .rot_imm_mode_i(rot_imm_mode_i), .imm_val_i(imm_val_i),
  .rot_field_i(rot_field_i), .result_o(result_o), .carry_o(carry_o)
);

// File: tb/barrel_shifter_test.sv
module barrel_shifter_test;
  localparam int CLK_HALF = 10;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic        mode;
    logic        imm;
    logic [1:0]  kind;
    logic [7:0]  amt;
    logic [31:0] src;
    logic        cin;
    logic [7:0]  val;
    logic [3:0]  rot;
    logic [31:0] res;
    logic        c;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,2'd0,8'd4,  32'h1234_5678,1'b0,8'h00,4'd0,32'h2345_6780,1'b1,8'd1},  // R1
    '{1'b0,1'b0,2'd1,8'd8,  32'h1234_5678,1'b0,8'h00,4'd0,32'h0012_3456,1'b0,8'd1},  // R1
    '{1'b0,1'b0,2'd2,8'd4,  32'h8000_00F0,1'b0,8'h00,4'd0,32'hF800_000F,1'b0,8'd1},  // R1
    '{1'b0,1'b0,2'd3,8'd8,  32'h1234_5678,1'b0,8'h00,4'd0,32'h7812_3456,1'b0,8'd1},  // R1
    '{1'b0,1'b0,2'd3,8'd1,  32'h0000_0001,1'b0,8'h00,4'd0,32'h8000_0000,1'b1,8'd1},  // R1
    '{1'b0,1'b1,2'd0,8'd0,  32'hDEAD_BEEF,1'b1,8'h00,4'd0,32'hDEAD_BEEF,1'b1,8'd3},  // R3
    '{1'b0,1'b1,2'd1,8'd0,  32'h8000_0000,1'b0,8'h00,4'd0,32'h0000_0000,1'b1,8'd4},  // R4
    '{1'b0,1'b1,2'd2,8'd0,  32'h8000_0000,1'b0,8'h00,4'd0,32'hFFFF_FFFF,1'b1,8'd5},  // R5
    '{1'b0,1'b1,2'd2,8'd0,  32'h7FFF_FFFF,1'b1,8'h00,4'd0,32'h0000_0000,1'b0,8'd5},  // R5
    '{1'b0,1'b1,2'd3,8'd0,  32'h0000_0003,1'b1,8'h00,4'd0,32'h8000_0001,1'b1,8'd6},  // R6
    '{1'b0,1'b1,2'd3,8'd0,  32'h0000_0002,1'b0,8'h00,4'd0,32'h0000_0001,1'b0,8'd6},  // R6
    '{1'b0,1'b1,2'd0,8'hE4, 32'h1234_5678,1'b0,8'h00,4'd0,32'h2345_6780,1'b1,8'd7},  // R7
    '{1'b0,1'b1,2'd1,8'h20, 32'h8000_0001,1'b0,8'h00,4'd0,32'h0000_0000,1'b1,8'd7},  // R7
    '{1'b0,1'b0,2'd3,8'd0,  32'hCAFE_F00D,1'b1,8'h00,4'd0,32'hCAFE_F00D,1'b1,8'd8},  // R8
    '{1'b0,1'b0,2'd2,8'd0,  32'h8000_0000,1'b0,8'h00,4'd0,32'h8000_0000,1'b0,8'd8},  // R8
    '{1'b0,1'b0,2'd0,8'd32, 32'h0000_0001,1'b0,8'h00,4'd0,32'h0000_0000,1'b1,8'd9},  // R9
    '{1'b0,1'b0,2'd0,8'd33, 32'hFFFF_FFFF,1'b1,8'h00,4'd0,32'h0000_0000,1'b0,8'd9},  // R9
    '{1'b0,1'b0,2'd1,8'd32, 32'h8000_0000,1'b0,8'h00,4'd0,32'h0000_0000,1'b1,8'd9},  // R9
    '{1'b0,1'b0,2'd1,8'd200,32'hFFFF_FFFF,1'b1,8'h00,4'd0,32'h0000_0000,1'b0,8'd9},  // R9
    '{1'b0,1'b0,2'd2,8'd32, 32'h8000_0000,1'b0,8'h00,4'd0,32'hFFFF_FFFF,1'b1,8'd10}, // R10
    '{1'b0,1'b0,2'd2,8'd255,32'h7FFF_FFFF,1'b1,8'h00,4'd0,32'h0000_0000,1'b0,8'd10}, // R10
    '{1'b0,1'b0,2'd3,8'd36, 32'h1234_5678,1'b0,8'h00,4'd0,32'h8123_4567,1'b1,8'd11}, // R11
    '{1'b0,1'b0,2'd3,8'd64, 32'h8000_0001,1'b0,8'h00,4'd0,32'h8000_0001,1'b1,8'd11}, // R11
    '{1'b0,1'b0,2'd3,8'd32, 32'h0000_0001,1'b1,8'h00,4'd0,32'h0000_0001,1'b0,8'd11}, // R11
    '{1'b1,1'b0,2'd0,8'd0,  32'h0000_0000,1'b0,8'hFF,4'd4,32'hFF00_0000,1'b1,8'd2},  // R2
    '{1'b1,1'b0,2'd0,8'd0,  32'h0000_0000,1'b0,8'h3F,4'd1,32'hC000_000F,1'b1,8'd2},  // R2
    '{1'b1,1'b0,2'd0,8'd0,  32'h0000_0000,1'b1,8'h01,4'd0,32'h0000_0001,1'b1,8'd2},  // R2
    '{1'b1,1'b0,2'd0,8'd0,  32'h0000_0000,1'b1,8'h04,4'd1,32'h0000_0001,1'b0,8'd2},  // R2
    '{1'b1,1'b0,2'd0,8'd0,  32'h0000_0000,1'b1,8'h81,4'd15,32'h0000_0204,1'b0,8'd2}, // R2
    '{1'b1,1'b1,2'd2,8'd5,  32'hFFFF_FFFF,1'b0,8'h80,4'd0,32'h0000_0080,1'b0,8'd12}  // R12
  };

  logic        clk, rst_n;
  logic [31:0] src;
  logic [7:0]  amt;
  logic [1:0]  kind;
  logic        amt_imm, cin, mode;
  logic [7:0]  val;
  logic [3:0]  rot;
  logic [31:0] res;
  logic        cout;
  int          n_chk, n_fail;

  barrel_shifter uut (
    .src_i(src), .amt_i(amt), .kind_i(kind), .amt_imm_i(amt_imm),
    .carry_i(cin), .rot_imm_mode_i(mode), .imm_val_i(val),
    .rot_field_i(rot), .result_o(res), .carry_o(cout)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  task automatic drive(input logic m, input logic im, input logic [1:0] k,
                       input logic [7:0] a, input logic [31:0] s, input logic ci,
                       input logic [7:0] v, input logic [3:0] r);
    @(posedge clk);
    mode = m; amt_imm = im; kind = k; amt = a; src = s; cin = ci; val = v; rot = r;
    @(negedge clk);
  endtask

  task automatic check(input logic [31:0] er, input logic ec, input string req);
    n_chk++;
    if (res !== er || cout !== ec) begin
      n_fail++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b", req, res, cout, er, ec);
    end
  endtask

  initial begin
    #(WATCHDOG * 2 * CLK_HALF);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    mode = 0; amt_imm = 0; kind = 0; amt = 0; src = 0; cin = 0; val = 0; rot = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(32'h0, 1'b0, "R8 idle");  // all-zero inputs after reset

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].mode, TBL[i].imm, TBL[i].kind, TBL[i].amt, TBL[i].src,
            TBL[i].cin, TBL[i].val, TBL[i].rot);
      check(TBL[i].res, TBL[i].c, $sformatf("R%0d vec %0d", TBL[i].req, i));
    end

    // R1: left-shift sweep of a single bit
    for (int n = 1; n < 32; n++) begin
      drive(1'b0, 1'b0, 2'd0, 8'(n), 32'h1, 1'b1, 8'h0, 4'd0);
      check(32'h1 << n, 1'b0, "R1 lsl sweep");
    end
    // R1: logical right sweep of the top bit
    for (int n = 1; n < 32; n++) begin
      drive(1'b0, 1'b0, 2'd1, 8'(n), 32'h8000_0000, 1'b1, 8'h0, 4'd0);
      check(32'h8000_0000 >> n, 1'b0, "R1 lsr sweep");
    end
    // R11: rotate amounts 33..63 act as 1..31
    for (int n = 33; n < 64; n++) begin
      drive(1'b0, 1'b0, 2'd3, 8'(n), 32'h1, 1'b0, 8'h0, 4'd0);
      check(32'h1 << (64 - n), (n == 33), "R11 ror modulo sweep");
    end
    // R7: upper amount bits ignored for every kind in instruction mode
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 1'b1, 2'(k), 8'h03, 32'hF0F0_1234, 1'b0, 8'h0, 4'd0);
      begin
        logic [31:0] r0;
        logic        c0;
        r0 = res; c0 = cout;
        drive(1'b0, 1'b1, 2'(k), 8'hE3, 32'hF0F0_1234, 1'b0, 8'h0, 4'd0);
        check(r0, c0, "R7 high amount bits");
      end
    end
    // R12: operand inputs swept in constant mode leave the output alone
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, k[0], 2'(k), 8'(k * 40), 32'h1357_9BDF << k, 1'b1, 8'hC3, 4'd2);
      check(32'h3000_000C, 1'b0, "R12 const mode");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule